// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits in the execute stage of a five-stage in-order pipeline and decides, for each of the two ALU operands, where the operand value comes from. It looks at the two source register indices held in the decode/execute pipeline register. It also looks at the destination index and write enable of the two older instructions that sit in the execute/memory and memory/writeback registers. An older instruction may be about to write a register that the current instruction reads. When it is, the block replaces the stale operand with the newer value.

The memory/writeback path carries the final value that will be written back, which is either loaded data or an ALU result. The execute/memory path carries the ALU result of the instruction directly ahead. When both older instructions target the same register as an operand, the closer one, in execute/memory, wins, because it is the later write in program order. Register index 0 is hard-wired to zero and is never a forwarding target.

The unit is purely combinational. It produces a 2-bit select per operand, which can drive an external operand multiplexer, and it also produces the selected operand value itself. Stall detection for load-use cases, register-file write-through and the ALU are outside this block.

Top module: `ex_operand_forward`

## Requirements
- R1: When the execute/memory write enable is 1, its destination index is nonzero and it equals an operand's source index, that operand's select is 2'b10 and the operand output equals the execute/memory ALU result.
- R2: When the memory/writeback write enable is 1, its destination index is nonzero and it equals an operand's source index, and the R1 condition is false for that operand, the select is 2'b01 and the operand output equals the memory/writeback value.
- R3: When the R1 and R2 conditions both hold for one operand, the execute/memory path is chosen (select 2'b10).
- R4: A stage whose destination index is 0 never forwards, even with its write enable set and a source index of 0.
- R5: A stage whose write enable is 0 never forwards, even when its destination matches the source index.
- R6: When neither stage forwards to an operand, its select is 2'b00 and the operand output equals the value read from the decode/execute register.
- R7: Operand A and operand B are decided independently by the same rules. The state of one never changes the select or the value of the other.
- R8: A select output never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | IDX_W | Source register index of operand A (decode/execute register) |
| src_b_idx | input | IDX_W | Source register index of operand B (decode/execute register) |
| rf_a_val | input | DATA_W | Operand A value read at decode |
| rf_b_val | input | DATA_W | Operand B value read at decode |
| exm_wr_en | input | 1 | Register write enable of the instruction in execute/memory |
| exm_dst_idx | input | IDX_W | Destination index of the instruction in execute/memory |
| exm_alu_val | input | DATA_W | ALU result held in execute/memory |
| mwb_wr_en | input | 1 | Register write enable of the instruction in memory/writeback |
| mwb_dst_idx | input | IDX_W | Destination index of the instruction in memory/writeback |
| mwb_wb_val | input | DATA_W | Final writeback value held in memory/writeback |
| sel_a | output | 2 | Operand A source: 00 register value, 10 execute/memory, 01 memory/writeback |
| sel_b | output | 2 | Operand B source, same encoding as sel_a |
| opnd_a | output | DATA_W | Selected operand A value |
| opnd_b | output | DATA_W | Selected operand B value |

## Verification
The bench builds the unit with IDX_W = 2 and DATA_W = 8. With these values every combination of both source indices, both destination indices and both write enables fits in 1024 vectors, so every input combination is driven. The sweep therefore covers the double-match priority case, writes aimed at register 0 and matches with a cleared enable for each operand. It also covers every pairing of operand A's situation with operand B's. The four data inputs carry distinct constants, so a wrong data route shows up as a wrong value even when the select is right.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Number of ALU operands that get a forwarding decision
  localparam int unsigned OPND_COUNT = 2;

  // Operand source select; encoding is visible on the top ports
  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_WBACK   = 2'b01,
    SEL_EXMEM   = 2'b10
  } fwd_sel_e;

endpackage

// File: rtl/fwd_stage_match.sv
// Decides whether one older pipeline stage can supply one operand.
module fwd_stage_match #(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] src_idx,
  input  logic             stg_wr_en,
  input  logic [IDX_W-1:0] stg_dst_idx,
  output logic             hit
);

  localparam logic [IDX_W-1:0] ZERO_IDX = '0;

  logic dst_live;
  logic idx_equal;

  always_comb begin
    dst_live  = stg_wr_en && (stg_dst_idx != ZERO_IDX);
    idx_equal = (stg_dst_idx == src_idx);
    hit       = dst_live && idx_equal;
  end

  always_comb begin
    // R4
    zero_dst_chk: assert (!(hit && (src_idx == ZERO_IDX)));
    // R5
    wr_en_gate_chk: assert (!(hit && !stg_wr_en));
  end

endmodule

// File: rtl/fwd_priority_sel.sv
// Resolves the two stage matches into one select, newest stage first.
module fwd_priority_sel
  import fwd_pkg::*;
(
  input  logic     exm_hit,
  input  logic     mwb_hit,
  output fwd_sel_e sel
);

  always_comb begin
    if (exm_hit) begin
      sel = SEL_EXMEM;
    end else if (mwb_hit) begin
      sel = SEL_WBACK;
    end else begin
      sel = SEL_REGFILE;
    end
  end

  always_comb begin
    // R3
    exm_first_chk: assert (!exm_hit || (sel == SEL_EXMEM));
    // R8
    sel_legal_chk: assert (sel != fwd_sel_e'(2'b11));
  end

endmodule

// File: rtl/fwd_operand_mux.sv
// Routes the chosen source onto one operand.
module fwd_operand_mux
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  fwd_sel_e          sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] exm_val,
  input  logic [DATA_W-1:0] wb_val,
  output logic [DATA_W-1:0] opnd
);

  always_comb begin
    unique case (sel)
      SEL_EXMEM: opnd = exm_val;
      SEL_WBACK: opnd = wb_val;
      default:   opnd = rf_val;
    endcase
  end

endmodule

// File: rtl/ex_operand_forward.sv
// Execute-stage forwarding: per-operand select and selected value.
module ex_operand_forward
  import fwd_pkg::*;
#(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic [IDX_W-1:0]  src_a_idx,
  input  logic [IDX_W-1:0]  src_b_idx,
  input  logic [DATA_W-1:0] rf_a_val,
  input  logic [DATA_W-1:0] rf_b_val,
  input  logic              exm_wr_en,
  input  logic [IDX_W-1:0]  exm_dst_idx,
  input  logic [DATA_W-1:0] exm_alu_val,
  input  logic              mwb_wr_en,
  input  logic [IDX_W-1:0]  mwb_dst_idx,
  input  logic [DATA_W-1:0] mwb_wb_val,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);

  localparam int unsigned N_OP = OPND_COUNT;

  logic [IDX_W-1:0]  src_idx [N_OP];
  logic [DATA_W-1:0] rf_val  [N_OP];
  logic [DATA_W-1:0] op_val  [N_OP];
  logic              exm_hit [N_OP];
  logic              mwb_hit [N_OP];
  fwd_sel_e          op_sel  [N_OP];

  always_comb begin
    src_idx[0] = src_a_idx;
    src_idx[1] = src_b_idx;
    rf_val[0]  = rf_a_val;
    rf_val[1]  = rf_b_val;
  end

  // One identical lane per operand
  for (genvar g = 0; g < N_OP; g++) begin : g_lane
    fwd_stage_match #(.IDX_W(IDX_W)) u_exm_match (
      .src_idx    (src_idx[g]),
      .stg_wr_en  (exm_wr_en),
      .stg_dst_idx(exm_dst_idx),
      .hit        (exm_hit[g])
    );

    fwd_stage_match #(.IDX_W(IDX_W)) u_mwb_match (
      .src_idx    (src_idx[g]),
      .stg_wr_en  (mwb_wr_en),
      .stg_dst_idx(mwb_dst_idx),
      .hit        (mwb_hit[g])
    );

    fwd_priority_sel u_prio (
      .exm_hit(exm_hit[g]),
      .mwb_hit(mwb_hit[g]),
      .sel    (op_sel[g])
    );

    fwd_operand_mux #(.DATA_W(DATA_W)) u_mux (
      .sel    (op_sel[g]),
      .rf_val (rf_val[g]),
      .exm_val(exm_alu_val),
      .wb_val (mwb_wb_val),
      .opnd   (op_val[g])
    );

    always_comb begin
      // R1
      exm_route_chk: assert ((op_sel[g] != SEL_EXMEM) || (op_val[g] == exm_alu_val));
      // R2
      wb_route_chk: assert ((op_sel[g] != SEL_WBACK) || (op_val[g] == mwb_wb_val));
      // R6
      rf_route_chk: assert ((op_sel[g] != SEL_REGFILE) || (op_val[g] == rf_val[g]));
    end
  end

  always_comb begin
    sel_a  = op_sel[0];
    sel_b  = op_sel[1];
    opnd_a = op_val[0];
    opnd_b = op_val[1];
  end

endmodule

// File: tb/tb_ex_operand_forward.sv
module tb_ex_operand_forward;

  localparam int unsigned IDX_W   = 2;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned CLK_PER = 10;
  localparam int unsigned WDOG_LIMIT = 20000;

  localparam logic [DATA_W-1:0] RF_A = 8'h1E;
  localparam logic [DATA_W-1:0] RF_B = 8'h2D;
  localparam logic [DATA_W-1:0] EXM  = 8'hA5;
  localparam logic [DATA_W-1:0] WBV  = 8'h5C;

  logic clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  logic [IDX_W-1:0]  src_a_idx, src_b_idx, exm_dst_idx, mwb_dst_idx;
  logic [DATA_W-1:0] rf_a_val, rf_b_val, exm_alu_val, mwb_wb_val;
  logic              exm_wr_en, mwb_wr_en;
  logic [1:0]        sel_a, sel_b;
  logic [DATA_W-1:0] opnd_a, opnd_b;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  ex_operand_forward #(.IDX_W(IDX_W), .DATA_W(DATA_W)) dut (
    .src_a_idx  (src_a_idx),
    .src_b_idx  (src_b_idx),
    .rf_a_val   (rf_a_val),
    .rf_b_val   (rf_b_val),
    .exm_wr_en  (exm_wr_en),
    .exm_dst_idx(exm_dst_idx),
    .exm_alu_val(exm_alu_val),
    .mwb_wr_en  (mwb_wr_en),
    .mwb_dst_idx(mwb_dst_idx),
    .mwb_wb_val (mwb_wb_val),
    .sel_a      (sel_a),
    .sel_b      (sel_b),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b)
  );

  // Expected select from the requirement rules
  function automatic logic [1:0] want_sel(input logic [IDX_W-1:0] s);
    bit e_ok, w_ok;
    e_ok = exm_wr_en && (exm_dst_idx != 0) && (exm_dst_idx == s);
    w_ok = mwb_wr_en && (mwb_dst_idx != 0) && (mwb_dst_idx == s);
    if (e_ok) return 2'b10;
    if (w_ok) return 2'b01;
    return 2'b00;
  endfunction

  // Which requirement a given operand situation exercises
  function automatic string tag_for(input logic [IDX_W-1:0] s);
    bit e_m, w_m;
    e_m = (exm_dst_idx == s);
    w_m = (mwb_dst_idx == s);
    if (exm_wr_en && w_m && mwb_wr_en && e_m && s != 0) return "R3";
    if (exm_wr_en && e_m && s != 0) return "R1";
    if (mwb_wr_en && w_m && s != 0) return "R2";
    if (s == 0 && ((exm_wr_en && e_m) || (mwb_wr_en && w_m))) return "R4";
    if ((e_m || w_m) && s != 0) return "R5";
    return "R6";
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h (srcA=%0d srcB=%0d exm we=%0b dst=%0d mwb we=%0b dst=%0d)",
               req, got, exp, src_a_idx, src_b_idx, exm_wr_en, exm_dst_idx,
               mwb_wr_en, mwb_dst_idx);
    end
  endtask

  task automatic check_lane(input string pre, input logic [IDX_W-1:0] s,
                            input logic [1:0] got_sel, input logic [DATA_W-1:0] got_val,
                            input logic [DATA_W-1:0] rfv);
    logic [1:0]        es;
    logic [DATA_W-1:0] ev;
    string             t;
    es = want_sel(s);
    ev = (es == 2'b10) ? EXM : (es == 2'b01) ? WBV : rfv;
    t  = {pre, tag_for(s)};
    chk({t, " sel"}, 32'(got_sel), 32'(es));
    chk({t, " val"}, 32'(got_val), 32'(ev));
    // R8: select code 11 is never produced
    total++;
    if (got_sel == 2'b11) begin
      bad++;
      $display("FAIL R8 sel got=%0h exp=not 3", got_sel);
    end
  endtask

  initial begin
    src_a_idx = '0; src_b_idx = '0; exm_dst_idx = '0; mwb_dst_idx = '0;
    exm_wr_en = 1'b0; mwb_wr_en = 1'b0;
    rf_a_val = RF_A; rf_b_val = RF_B; exm_alu_val = EXM; mwb_wb_val = WBV;
    @(negedge clk);
    // Idle state: nothing forwards, R6
    chk("R6 idle sel_a", 32'(sel_a), 32'h0);
    chk("R6 idle sel_b", 32'(sel_b), 32'h0);
    chk("R6 idle opnd_a", 32'(opnd_a), 32'(RF_A));
    chk("R6 idle opnd_b", 32'(opnd_b), 32'(RF_B));

    // Exhaustive sweep; operand B lane checks carry the R7 prefix
    for (int i = 0; i < 1024; i++) begin
      logic [9:0] v;
      v = 10'(i);
      src_a_idx   = v[1:0];
      src_b_idx   = v[3:2];
      exm_dst_idx = v[5:4];
      exm_wr_en   = v[6];
      mwb_dst_idx = v[8:7];
      mwb_wr_en   = v[9];
      #(CLK_PER/2);
      check_lane("",    src_a_idx, sel_a, opnd_a, RF_A);
      check_lane("R7 ", src_b_idx, sel_b, opnd_b, RF_B);
      @(negedge clk);
    end

    // Directed: both stages write r3 (r3 = index 3), A reads it, B reads r1 - R3 and R7
    src_a_idx = 2'd3; src_b_idx = 2'd1;
    exm_wr_en = 1'b1; exm_dst_idx = 2'd3;
    mwb_wr_en = 1'b1; mwb_dst_idx = 2'd3;
    exm_alu_val = 8'h77; mwb_wb_val = 8'h88;
    #(CLK_PER/2);
    chk("R3 directed opnd_a", 32'(opnd_a), 32'h77);
    chk("R7 directed opnd_b", 32'(opnd_b), 32'(RF_B));
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG_LIMIT && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog got=%0d exp=<%0d", cyc, WDOG_LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule